// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block chooses the next fetch address for a 32-bit RISC pipeline whose control transfers take effect one instruction late. Each issued instruction arrives with its own PC, a decoded transfer kind, a 16-bit branch offset, a 26-bit jump index and the two source register values. The block resolves the transfer outcome from the register values alone; there are no flags. It reports whether the transfer is taken and, for jump-and-link, provides the return address and a write enable for the link register (register 31).

A taken transfer does not redirect fetch at once. The instruction that follows it, in the delay slot, always issues. A two-state machine records the resolved target. It applies the target to the fetch that follows the slot instruction. A not-taken transfer lets the slot fall through to its own PC+4. A transfer that sits in a delay slot is reported as illegal and has no effect of its own. When nothing issues, the fetch address holds.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, and in the first issue after it, the unit is outside a delay slot: `taken_o`, `link_we_o` and `slot_illegal_o` are 0, and `next_pc_o` is `pc_i`+4 for an issued instruction.
- R2: An issued non-transfer instruction outside a slot gives `next_pc_o` = `pc_i`+4 and `taken_o` = 0. Kind codes 0 and 10 to 15 are non-transfers.
- R3: Two-register compares use kind 1 (taken when rs equals rt) and kind 2 (taken when they differ). The target is `pc_i`+4 plus the sign-extended offset shifted left by two.
- R4: Signed zero compares on rs, with the same target as R3, use these kinds: 3 (taken when rs <= 0), 4 (taken when rs > 0), 5 (taken when rs < 0) and 6 (taken when rs >= 0).
- R5: Kind 7 is always taken. Its target is bits 31:28 of `pc_i`+4, then the 26-bit index, then two zero bits.
- R6: Kind 8 is always taken, with rs as its target.
- R7: Kind 9 is always taken with the R5 target. In the same cycle it asserts `link_we_o` with `link_val_o` = `pc_i`+4.
- R8: An issued transfer outside a slot gives `next_pc_o` = `pc_i`+4 and raises `in_slot_o` from the next cycle on. The next issued instruction gets the latched target if the transfer was taken and its own `pc_i`+4 otherwise. It then leaves the slot.
- R9: A transfer issued in a delay slot raises `slot_illegal_o`. It keeps `taken_o` and `link_we_o` low, and `next_pc_o` still follows the pending outcome.
- R10: With `issue_i` low, `next_pc_o` = `pc_i`, `taken_o` and `link_we_o` are 0, and the slot state and pending target are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction issues this cycle |
| pc_i | input | 32 | PC of the issuing instruction |
| xfer_i | input | 4 | Transfer kind code |
| offset_i | input | 16 | Branch word offset |
| jidx_i | input | 26 | Direct jump word index |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | The issuing transfer is taken |
| link_val_o | output | 32 | Return address for the link register |
| link_we_o | output | 1 | Link register write enable |
| in_slot_o | output | 1 | The next issue is a delay-slot instruction |
| slot_illegal_o | output | 1 | A transfer was issued in a delay slot |

## Verification
The pending redirect of an earlier taken branch and a new transfer decoded in its delay slot can land in the same cycle. The unit must then both apply the old target and refuse the new one. Directed sequences place each transfer kind straight after a taken and after a not-taken branch, and random stimulus hits the case often. In that cycle the bench expects the latched target (or PC+4) on `next_pc_o` together with `slot_illegal_o` high and no taken or link write. Stalls inside a slot are mixed in to show that the pending target survives them.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    XF_NONE = 4'd0,
    XF_BEQ  = 4'd1,
    XF_BNE  = 4'd2,
    XF_BLEZ = 4'd3,
    XF_BGTZ = 4'd4,
    XF_BLTZ = 4'd5,
    XF_BGEZ = 4'd6,
    XF_J    = 4'd7,
    XF_JR   = 4'd8,
    XF_JAL  = 4'd9
  } xfer_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_SLOT = 1'b1
  } slot_st_e;

  function automatic logic is_xfer(input logic [3:0] k);
    return (k >= 4'd1) && (k <= 4'd9);
  endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            ok_o
);

  logic neg, zero, eq;

  always_comb begin
    neg  = a_i[XLEN-1];
    zero = (a_i == '0);
    eq   = (a_i == b_i);
    unique case (kind_i)
      XF_BEQ:                ok_o = eq;
      XF_BNE:                ok_o = !eq;
      XF_BLEZ:               ok_o = neg || zero;
      XF_BGTZ:               ok_o = !neg && !zero;
      XF_BLTZ:               ok_o = neg;
      XF_BGEZ:               ok_o = !neg;
      XF_J, XF_JR, XF_JAL:   ok_o = 1'b1;
      default:               ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [3:0]       kind_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  rs_i,
  output logic [XLEN-1:0]  pc4_o,
  output logic [XLEN-1:0]  tgt_o
);

  localparam int HI_W  = XLEN - IDX_W - 2;
  localparam int EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] br_tgt, jmp_tgt, off_ext;

  always_comb begin
    pc4_o   = pc_i + XLEN'(4);
    off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
    br_tgt  = pc4_o + off_ext;
    jmp_tgt = {pc4_o[XLEN-1 -: HI_W], idx_i, 2'b00};
    unique case (kind_i)
      XF_J, XF_JAL: tgt_o = jmp_tgt;
      XF_JR:        tgt_o = rs_i;
      default:      tgt_o = br_tgt;
    endcase
  end

endmodule

// File: rtl/npc_slot_fsm.sv
module npc_slot_fsm
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic            load_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] tgt_i,
  output logic            in_slot_o,
  output logic            pend_taken_o,
  output logic [XLEN-1:0] pend_tgt_o
);

  slot_st_e state_q, state_d;
  logic     ptaken_d;

  always_comb begin
    state_d  = state_q;
    ptaken_d = pend_taken_o;
    if (issue_i) begin
      if (state_q == S_SLOT) begin
        state_d  = S_IDLE;
        ptaken_d = 1'b0;
      end else if (load_i) begin
        state_d  = S_SLOT;
        ptaken_d = taken_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      pend_taken_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      pend_taken_o <= ptaken_d;
    end
  end

  always_ff @(posedge clk) begin
    if (issue_i && load_i && state_q == S_IDLE) begin
      pend_tgt_o <= tgt_i;
    end
  end

  assign in_slot_o = (state_q == S_SLOT);

  // R8
  slot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot_o && issue_i) |=> !in_slot_o);

  // R8
  slot_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_slot_o && issue_i && load_i) |=> in_slot_o);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> ($stable(in_slot_o) && $stable(pend_taken_o)));

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [3:0]       xfer_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [IDX_W-1:0] jidx_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  link_val_o,
  output logic             link_we_o,
  output logic             in_slot_o,
  output logic             slot_illegal_o
);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            cond_ok, xfer_any, xfer_legal;
  logic            pend_taken;
  logic [XLEN-1:0] pc4, tgt, pend_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i (xfer_i),
    .a_i    (rs_val_i),
    .b_i    (rt_val_i),
    .ok_o   (cond_ok)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
    .pc_i   (pc_i),
    .kind_i (xfer_i),
    .off_i  (offset_i),
    .idx_i  (jidx_i),
    .rs_i   (rs_val_i),
    .pc4_o  (pc4),
    .tgt_o  (tgt)
  );

  npc_slot_fsm #(.XLEN(XLEN)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .issue_i      (issue_i),
    .load_i       (xfer_any),
    .taken_i      (cond_ok),
    .tgt_i        (tgt),
    .in_slot_o    (in_slot_o),
    .pend_taken_o (pend_taken),
    .pend_tgt_o   (pend_tgt)
  );

  always_comb begin
    xfer_any       = is_xfer(xfer_i);
    xfer_legal     = issue_i && xfer_any && !in_slot_o;
    taken_o        = xfer_legal && cond_ok;
    link_we_o      = xfer_legal && (xfer_i == XF_JAL);
    link_val_o     = pc4;
    slot_illegal_o = issue_i && xfer_any && in_slot_o;
    if (!issue_i)                       next_pc_o = pc_i;
    else if (in_slot_o && pend_taken)   next_pc_o = pend_tgt;
    else                                next_pc_o = pc4;
  end

  // R8
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    taken_o |=> (issue_i |-> next_pc_o == $past(tgt)));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    slot_illegal_o |-> (!taken_o && !link_we_o));

  // R7
  link_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    link_we_o |-> (taken_o && link_val_o == pc_i + XLEN'(4)));

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !issue_i |-> (next_pc_o == pc_i && !taken_o && !link_we_o));

  // R2
  seq_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (issue_i && !in_slot_o) |-> (next_pc_o == pc_i + XLEN'(4)));

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

  localparam time CYC = 20ns;

  logic        clk, rst_n, issue;
  logic [31:0] pc, rs, rt;
  logic [3:0]  kind;
  logic [15:0] off;
  logic [25:0] idx;
  logic [31:0] next_pc, link_val;
  logic        taken, link_we, in_slot, illegal;

  int n_chk = 0;
  int n_bad = 0;

  logic        m_slot, m_pt;
  logic [31:0] m_ptg;

  npc_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .pc_i(pc), .xfer_i(kind),
    .offset_i(off), .jidx_i(idx), .rs_val_i(rs), .rt_val_i(rt),
    .next_pc_o(next_pc), .taken_o(taken), .link_val_o(link_val),
    .link_we_o(link_we), .in_slot_o(in_slot), .slot_illegal_o(illegal)
  );

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got=%h exp=%h", rq, what, got, exp);
    end
  endtask

  function automatic logic x_any(input logic [3:0] k);
    return k >= 4'd1 && k <= 4'd9;
  endfunction

  function automatic logic exp_cond(input logic [3:0] k, input logic [31:0] a, b);
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) <= 0;
      4'd4: return $signed(a) > 0;
      4'd5: return $signed(a) < 0;
      4'd6: return $signed(a) >= 0;
      4'd7, 4'd8, 4'd9: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_tgt(input logic [3:0] k, input logic [31:0] p,
      input logic [15:0] o, input logic [25:0] j, input logic [31:0] a);
    logic [31:0] p4;
    p4 = p + 32'd4;
    if (k == 4'd7 || k == 4'd9) return {p4[31:28], j, 2'b00};
    if (k == 4'd8) return a;
    return p4 + {{14{o[15]}}, o, 2'b00};
  endfunction

  function automatic string tag_of(input logic is, input logic sl, input logic [3:0] k);
    if (!is) return "R10";
    if (sl) return x_any(k) ? "R9" : "R8";
    case (k)
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4, 4'd5, 4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic step(input logic i_is, input logic [31:0] i_pc, input logic [3:0] i_k,
                      input logic [15:0] i_o, input logic [25:0] i_j,
                      input logic [31:0] i_rs, input logic [31:0] i_rt);
    string rq;
    logic e_tk, e_we, e_il;
    logic [31:0] e_np;
    @(negedge clk);
    issue = i_is; pc = i_pc; kind = i_k; off = i_o; idx = i_j; rs = i_rs; rt = i_rt;
    #1;
    rq = tag_of(i_is, m_slot, i_k);
    chk(rq, "in_slot", 32'(in_slot), 32'(m_slot));
    e_tk = 1'b0; e_we = 1'b0; e_il = 1'b0;
    if (!i_is) begin
      e_np = i_pc;
    end else if (m_slot) begin
      e_il = x_any(i_k);
      e_np = m_pt ? m_ptg : i_pc + 32'd4;
      m_slot = 1'b0; m_pt = 1'b0;
    end else begin
      e_np = i_pc + 32'd4;
      if (x_any(i_k)) begin
        e_tk = exp_cond(i_k, i_rs, i_rt);
        e_we = (i_k == 4'd9);
        m_slot = 1'b1; m_pt = e_tk;
        m_ptg = exp_tgt(i_k, i_pc, i_o, i_j, i_rs);
      end
    end
    chk(rq, "next_pc", next_pc, e_np);
    chk(rq, "taken", 32'(taken), 32'(e_tk));
    chk(rq, "link_we", 32'(link_we), 32'(e_we));
    chk(rq, "illegal", 32'(illegal), 32'(e_il));
    if (e_we) chk(rq, "link_val", link_val, i_pc + 32'd4);
  endtask

  initial begin
    #(CYC * 200000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog got=%0d exp=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    m_slot = 1'b0; m_pt = 1'b0; m_ptg = '0;
    rst_n = 1'b0; issue = 1'b1; pc = 32'h0000_1000; kind = 4'd0;
    off = '0; idx = '0; rs = '0; rt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 outputs quiet during reset
    chk("R1", "taken", 32'(taken), 0);
    chk("R1", "link_we", 32'(link_we), 0);
    chk("R1", "illegal", 32'(illegal), 0);
    chk("R1", "next_pc", next_pc, 32'h0000_1004);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 first issue after reset
    step(1, 32'h0000_2000, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    // R3 taken equal, then slot redirects to 0x2008-8
    step(1, 32'h0000_2004, 4'd1, 16'hFFFE, 26'h0, 32'h55, 32'h55);
    step(1, 32'h0000_2008, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    // R3 not-equal not taken, slot falls through
    step(1, 32'h0000_3000, 4'd2, 16'h0010, 26'h0, 32'h7, 32'h7);
    step(1, 32'h0000_3004, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    // R4 sign boundaries
    step(1, 32'h0000_4000, 4'd3, 16'h0004, 26'h0, 32'h0, 32'h0);
    step(1, 32'h0000_4004, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    step(1, 32'h0000_4100, 4'd4, 16'h0004, 26'h0, 32'h0, 32'h0);
    step(1, 32'h0000_4104, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    step(1, 32'h0000_4200, 4'd5, 16'h8000, 26'h0, 32'h8000_0000, 32'h0);
    step(1, 32'h0000_4204, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    step(1, 32'h0000_4300, 4'd6, 16'h7FFF, 26'h0, 32'h0, 32'h0);
    step(1, 32'h0000_4304, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    // R5 direct jump across region bits
    step(1, 32'hEFFF_FFFC, 4'd7, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0);
    step(1, 32'hF000_0000, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    // R6 register jump
    step(1, 32'h0000_5000, 4'd8, 16'h0, 26'h0, 32'h1234_5678, 32'h0);
    step(1, 32'h0000_5004, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    // R7 link, R9 transfer in slot
    step(1, 32'h0000_6000, 4'd9, 16'h0, 26'h000_0040, 32'h0, 32'h0);
    step(1, 32'h0000_6004, 4'd8, 16'h0, 26'h0, 32'h9999_0000, 32'h0);
    // R10 stall inside slot keeps pending target
    step(1, 32'h0000_7000, 4'd1, 16'h0020, 26'h0, 32'h1, 32'h1);
    step(0, 32'h0000_7004, 4'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    step(0, 32'h0000_7004, 4'd9, 16'h0, 26'h0, 32'h0, 32'h0);
    step(1, 32'h0000_7004, 4'd9, 16'h0, 26'h0, 32'h0, 32'h0);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r_rs, r_rt;
      case ($urandom_range(0, 3))
        0: r_rs = 32'h0;
        1: r_rs = 32'h8000_0000;
        default: r_rs = $urandom;
      endcase
      r_rt = ($urandom_range(0, 1) == 1) ? r_rs : $urandom;
      step(($urandom_range(0, 7) != 0), {$urandom_range(0, 32'h3FFF_FFFF), 2'b00}
           + 32'h0, 4'($urandom_range(0, 11)), 16'($urandom), 26'($urandom),
           r_rs, r_rt);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule